// File: doc/BRIEF.md
# Capture and Asymmetric PWM Register Bank

This block holds four 32-bit storage registers beside a free-running 32-bit timer count. The registers change role with the operating mode. In capture mode each register is a timestamp slot. It copies the current count when its own load strobe fires, provided the load-enable bit is set. In one-shot operation the load-enable bit drops by itself once the capture that forms the programmed stop event has been taken. A bus write to the bit arms capture again.

In asymmetric PWM mode, register 1 holds the active period and register 2 holds the active compare value. Registers 3 and 4 are their shadows. A new value written to a shadow reaches the active register in one of two ways: on the same edge as the write (immediate), or on the next edge where the count equals the active period (deferred). The edge qualifiers, the modulo-4 event sequencer and the PWM output stage sit outside this block. The strobes and the stop index arrive as inputs.

Top module: `cpr_bank`

## Requirements
- R1: In capture mode with load-enable set, a high on `cap_stb_i[k]` loads `count_i` into register k+1 at that clock edge (bit 0 selects register 1, bit 3 selects register 4).
- R2: In capture mode with load-enable clear, strobes leave all four registers unchanged.
- R3: In one-shot mode, a strobe that loads register `stop_idx_i`+1 still captures. Load-enable reads 0 from the next cycle on, so later strobes are ignored.
- R4: With one-shot off, load-enable keeps its value whatever strobes arrive; it changes only by bus write.
- R5: A write on `lden_wr_i` sets load-enable to `lden_wdata_i` at the next edge. This takes priority over a one-shot stop on the same edge.
- R6: A bus write (`wr_idx_i` 0..3 selects register 1..4) loads `wr_data_i`. In capture mode, a strobe for the same register on the same edge wins, and the register takes the count.
- R7: In capture mode, registers 3 and 4 never transfer into registers 1 and 2, by write or by count match.
- R8: In PWM mode, capture strobes change no register and do not affect load-enable.
- R9: In PWM mode with immediate shadow loading, a write to index 2 loads both register 3 and register 1 on that edge. A write to index 3 loads both register 4 and register 2.
- R10: In PWM mode with deferred shadow loading, on an edge where `count_i` equals register 1, register 1 takes register 3 and register 2 takes register 4, using the values held before that edge. A shadow write on the same edge updates only the shadow and is applied at the next match.
- R11: Synchronous reset clears all four registers and load-enable to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| count_i | input | 32 | Free-running timer count |
| cap_stb_i | input | 4 | Per-register capture strobes from the sequencer |
| pwm_mode_i | input | 1 | 0 capture mode, 1 asymmetric PWM mode |
| oneshot_i | input | 1 | 1 enables automatic load-enable clear at the stop event |
| stop_idx_i | input | 2 | Register index (0..3) whose capture is the stop event |
| shadow_imm_i | input | 1 | 1 immediate shadow transfer, 0 transfer on period match |
| wr_en_i | input | 1 | Bus write strobe for the registers |
| wr_idx_i | input | 2 | Register index for the bus write |
| wr_data_i | input | 32 | Bus write data |
| lden_wr_i | input | 1 | Bus write strobe for load-enable |
| lden_wdata_i | input | 1 | Value written to load-enable |
| reg1_o | output | 32 | Register 1 (timestamp or active period) |
| reg2_o | output | 32 | Register 2 (timestamp or active compare) |
| reg3_o | output | 32 | Register 3 (timestamp or period shadow) |
| reg4_o | output | 32 | Register 4 (timestamp or compare shadow) |
| lden_o | output | 1 | Current load-enable state |

## Verification
Two function pairs can coincide on one edge. In deferred PWM mode, a period match can meet a write to the period shadow. In one-shot capture, the stop capture can meet a bus re-arm of load-enable. The bench sets the count equal to register 1 while writing index 2. It expects register 1 to take the old shadow and register 3 the new data, with the new data reaching register 1 only at the following match. It also drives the stop strobe together with a load-enable write of 1, and expects both the capture and a load-enable that stays set.

// File: rtl/cpr_pkg.sv
// Shared constants for the capture / PWM register bank.
// Assumes exactly four register slots; the roles depend on that count.
package cpr_pkg;
    localparam int CPR_NREG    = 4;
    localparam int CPR_IDX_W   = $clog2(CPR_NREG);
    // Slot indices whose role changes in PWM mode
    localparam int IDX_PER     = 0;
    localparam int IDX_CMP     = 1;
    localparam int IDX_SHD_PER = 2;
    localparam int IDX_SHD_CMP = 3;
    localparam int CPR_NACT    = 2;   // active slots fed by shadows

    typedef enum logic {
        MODE_CAPTURE = 1'b0,
        MODE_PWM     = 1'b1
    } cpr_mode_e;
endpackage

// File: rtl/cpr_slot.sv
// One storage slot. Priority: capture load, then shadow transfer, then bus write.
// Assumes the caller gates cap_ld with mode and load-enable.
module cpr_slot #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_ld,
    input  logic [DW-1:0] cnt_i,
    input  logic          xfer_ld,
    input  logic [DW-1:0] xfer_d,
    input  logic          wr_ld,
    input  logic [DW-1:0] wr_d,
    output logic [DW-1:0] q
);
    // Slot register update with fixed source priority
    always_ff @(posedge clk) begin
        if (!rst_n)       q <= '0;
        else if (cap_ld)  q <= cnt_i;
        else if (xfer_ld) q <= xfer_d;
        else if (wr_ld)   q <= wr_d;
    end

    // R1 / R6: a capture load always stores the count of that edge
    p_capture_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cap_ld |=> (q == $past(cnt_i)));
endmodule

// File: rtl/cpr_lden_ctl.sv
// Load-enable bit: set or cleared by bus write, auto-cleared at a one-shot stop.
// Assumes stop_hit_i is already qualified with capture mode and load-enable.
module cpr_lden_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_i,
    input  logic wdata_i,
    input  logic oneshot_i,
    input  logic stop_hit_i,
    output logic lden_o
);
    // Bus write wins over the automatic clear
    always_ff @(posedge clk) begin
        if (!rst_n)                       lden_o <= 1'b0;
        else if (wr_i)                    lden_o <= wdata_i;
        else if (oneshot_i && stop_hit_i) lden_o <= 1'b0;
    end

    p_oneshot_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (oneshot_i && stop_hit_i && !wr_i) |=> !lden_o);
    p_free_run_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!oneshot_i && !wr_i) |=> $stable(lden_o));
    p_bus_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (lden_o == $past(wdata_i)));
endmodule

// File: rtl/cpr_shadow_ctl.sv
// Decides when shadow slots move into the active period / compare slots.
// Immediate: the write data goes straight through. Deferred: the old shadow moves on count == period.
// Assumes pwm_i low means capture mode, where all transfer is locked out.
module cpr_shadow_ctl #(
    parameter int DW = 32
) (
    input  logic                           pwm_i,
    input  logic                           imm_i,
    input  logic [DW-1:0]                  cnt_i,
    input  logic [DW-1:0]                  per_i,
    input  logic                           wr_en_i,
    input  logic [cpr_pkg::CPR_IDX_W-1:0]  wr_idx_i,
    input  logic [DW-1:0]                  wr_data_i,
    input  logic [DW-1:0]                  shd_per_i,
    input  logic [DW-1:0]                  shd_cmp_i,
    output logic [cpr_pkg::CPR_NACT-1:0]   xfer_ld_o,
    output logic [DW-1:0]                  xfer_per_o,
    output logic [DW-1:0]                  xfer_cmp_o
);
    import cpr_pkg::*;

    logic period_hit;
    logic wr_shd_per;
    logic wr_shd_cmp;

    // Decode the shadow-slot writes and the period match
    always_comb begin
        period_hit = (cnt_i == per_i);
        wr_shd_per = wr_en_i && (wr_idx_i == CPR_IDX_W'(IDX_SHD_PER));
        wr_shd_cmp = wr_en_i && (wr_idx_i == CPR_IDX_W'(IDX_SHD_CMP));
    end

    // Pick the transfer source and strobe for each active slot
    always_comb begin
        xfer_ld_o  = '0;
        xfer_per_o = shd_per_i;
        xfer_cmp_o = shd_cmp_i;
        if (pwm_i) begin
            if (imm_i) begin
                xfer_ld_o[IDX_PER] = wr_shd_per;
                xfer_ld_o[IDX_CMP] = wr_shd_cmp;
                xfer_per_o         = wr_data_i;
                xfer_cmp_o         = wr_data_i;
            end else begin
                xfer_ld_o = {CPR_NACT{period_hit}};
            end
        end
    end
endmodule

// File: rtl/cpr_bank.sv
// Top of the capture / asymmetric PWM register bank.
// Four slots are timestamps in capture mode; in PWM mode they are active period,
// active compare and their two shadows. Assumes strobes are one-cycle pulses.
module cpr_bank #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] count_i,
    input  logic [3:0]    cap_stb_i,
    input  logic          pwm_mode_i,
    input  logic          oneshot_i,
    input  logic [1:0]    stop_idx_i,
    input  logic          shadow_imm_i,
    input  logic          wr_en_i,
    input  logic [1:0]    wr_idx_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic          lden_wr_i,
    input  logic          lden_wdata_i,
    output logic [DW-1:0] reg1_o,
    output logic [DW-1:0] reg2_o,
    output logic [DW-1:0] reg3_o,
    output logic [DW-1:0] reg4_o,
    output logic          lden_o
);
    import cpr_pkg::*;

    cpr_mode_e                 mode;
    logic                      lden_q;
    logic                      stop_hit;
    logic [CPR_NREG-1:0]       cap_ld;
    logic [CPR_NREG-1:0]       wr_ld;
    logic [CPR_NREG-1:0]       xfer_ld;
    logic [DW-1:0]             xfer_d [CPR_NREG];
    logic [DW-1:0]             slot_q [CPR_NREG];
    logic [CPR_NACT-1:0]       act_ld;
    logic [DW-1:0]             act_per_d;
    logic [DW-1:0]             act_cmp_d;

    // Mode decode and the one-shot stop event
    always_comb begin
        mode     = pwm_mode_i ? MODE_PWM : MODE_CAPTURE;
        stop_hit = lden_q && (mode == MODE_CAPTURE) && cap_stb_i[stop_idx_i];
    end

    cpr_lden_ctl u_lden (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (lden_wr_i),
        .wdata_i    (lden_wdata_i),
        .oneshot_i  (oneshot_i),
        .stop_hit_i (stop_hit),
        .lden_o     (lden_q)
    );

    cpr_shadow_ctl #(.DW(DW)) u_shadow (
        .pwm_i      (mode == MODE_PWM),
        .imm_i      (shadow_imm_i),
        .cnt_i      (count_i),
        .per_i      (slot_q[IDX_PER]),
        .wr_en_i    (wr_en_i),
        .wr_idx_i   (wr_idx_i),
        .wr_data_i  (wr_data_i),
        .shd_per_i  (slot_q[IDX_SHD_PER]),
        .shd_cmp_i  (slot_q[IDX_SHD_CMP]),
        .xfer_ld_o  (act_ld),
        .xfer_per_o (act_per_d),
        .xfer_cmp_o (act_cmp_d)
    );

    // Route transfers to the active slots only
    always_comb begin
        for (int k = 0; k < CPR_NREG; k++) begin
            xfer_ld[k] = 1'b0;
            xfer_d[k]  = '0;
        end
        xfer_ld[IDX_PER] = act_ld[IDX_PER];
        xfer_d[IDX_PER]  = act_per_d;
        xfer_ld[IDX_CMP] = act_ld[IDX_CMP];
        xfer_d[IDX_CMP]  = act_cmp_d;
    end

    // One slot per register, with per-slot capture and write decode
    for (genvar k = 0; k < CPR_NREG; k++) begin : g_slot
        always_comb begin
            cap_ld[k] = cap_stb_i[k] && lden_q && (mode == MODE_CAPTURE);
            wr_ld[k]  = wr_en_i && (wr_idx_i == CPR_IDX_W'(k));
        end
        cpr_slot #(.DW(DW)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .cap_ld  (cap_ld[k]),
            .cnt_i   (count_i),
            .xfer_ld (xfer_ld[k]),
            .xfer_d  (xfer_d[k]),
            .wr_ld   (wr_ld[k]),
            .wr_d    (wr_data_i),
            .q       (slot_q[k])
        );
    end

    // Drive the outputs
    always_comb begin
        reg1_o = slot_q[IDX_PER];
        reg2_o = slot_q[IDX_CMP];
        reg3_o = slot_q[IDX_SHD_PER];
        reg4_o = slot_q[IDX_SHD_CMP];
        lden_o = lden_q;
    end

    p_inhibit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwm_mode_i && !lden_o && !wr_en_i) |=>
        ($stable(reg1_o) && $stable(reg2_o) && $stable(reg3_o) && $stable(reg4_o)));
    p_lockout_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwm_mode_i && !cap_stb_i[0] && !(wr_en_i && wr_idx_i == 2'd0)) |=> $stable(reg1_o));
    p_pwm_ignores_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_mode_i && !wr_en_i && !lden_wr_i && (shadow_imm_i || count_i != reg1_o)) |=>
        ($stable(reg1_o) && $stable(reg2_o) && $stable(reg3_o) && $stable(reg4_o) && $stable(lden_o)));
    p_immediate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_mode_i && shadow_imm_i && wr_en_i && wr_idx_i == 2'd2) |=>
        (reg1_o == $past(wr_data_i) && reg3_o == $past(wr_data_i)));
    p_deferred_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_mode_i && !shadow_imm_i && count_i == reg1_o) |=>
        (reg1_o == $past(reg3_o) && reg2_o == $past(reg4_o)));
endmodule

// File: tb/cpr_bank_bench.sv
// Scoreboard bench: the stimulus code queues expected values with the cycle they are due,
// and a monitor compares them one time unit after each rising edge.
module cpr_bank_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] count_i = '0;
    logic [3:0]  cap_stb_i = '0;
    logic        pwm_mode_i = 1'b0;
    logic        oneshot_i = 1'b0;
    logic [1:0]  stop_idx_i = '0;
    logic        shadow_imm_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [1:0]  wr_idx_i = '0;
    logic [31:0] wr_data_i = '0;
    logic        lden_wr_i = 1'b0;
    logic        lden_wdata_i = 1'b0;
    logic [31:0] reg1_o, reg2_o, reg3_o, reg4_o;
    logic        lden_o;

    always #2 clk = ~clk;   // 250 MHz

    cpr_bank u_cpr_bank (
        .clk(clk), .rst_n(rst_n), .count_i(count_i), .cap_stb_i(cap_stb_i),
        .pwm_mode_i(pwm_mode_i), .oneshot_i(oneshot_i), .stop_idx_i(stop_idx_i),
        .shadow_imm_i(shadow_imm_i), .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i),
        .wr_data_i(wr_data_i), .lden_wr_i(lden_wr_i), .lden_wdata_i(lden_wdata_i),
        .reg1_o(reg1_o), .reg2_o(reg2_o), .reg3_o(reg3_o), .reg4_o(reg4_o),
        .lden_o(lden_o)
    );

    typedef struct {
        int          due;
        int          sel;   // 0..3 register, 4 load-enable
        logic [31:0] val;
        string       req;
    } exp_t;

    exp_t exp_q[$];
    int   cyc = 0;
    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    function automatic logic [31:0] observe(int sel);
        case (sel)
            0: return reg1_o;
            1: return reg2_o;
            2: return reg3_o;
            3: return reg4_o;
            default: return {31'd0, lden_o};
        endcase
    endfunction

    // Queue an expectation for the state after the coming rising edge
    task automatic expect_v(int sel, logic [31:0] val, string req);
        exp_t e;
        e.due = cyc + 1;
        e.sel = sel;
        e.val = val;
        e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic expect_all(logic [31:0] a, logic [31:0] b, logic [31:0] c,
                              logic [31:0] d, logic l, string req);
        expect_v(0, a, req);
        expect_v(1, b, req);
        expect_v(2, c, req);
        expect_v(3, d, req);
        expect_v(4, {31'd0, l}, req);
    endtask

    // Let one rising edge pass, then drop the single-cycle pulses
    task automatic tick();
        @(negedge clk);
        cap_stb_i = '0;
        wr_en_i   = 1'b0;
        lden_wr_i = 1'b0;
    endtask

    task automatic bus_wr(logic [1:0] idx, logic [31:0] d);
        wr_en_i   = 1'b1;
        wr_idx_i  = idx;
        wr_data_i = d;
    endtask

    // Monitor: pop and compare the items due in this cycle
    always @(posedge clk) begin
        #1;
        cyc = cyc + 1;
        while (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
            exp_t e;
            logic [31:0] got;
            e = exp_q.pop_front();
            got = observe(e.sel);
            n_checks++;
            if (e.due != cyc || got !== e.val) begin
                n_fail++;
                $display("FAIL %s: slot %0d got %0d expected %0d (due %0d, now %0d)",
                         e.req, e.sel, got, e.val, e.due, cyc);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R11: reset state
        expect_all(0, 0, 0, 0, 1'b0, "R11 reset");
        tick();
        tick();
        rst_n = 1'b1;
        // R5: arm load-enable
        lden_wr_i = 1'b1; lden_wdata_i = 1'b1;
        expect_v(4, 1, "R5 arm");
        tick();
        // R1: captures into each slot
        count_i = 100; cap_stb_i = 4'b0001; expect_v(0, 100, "R1 slot1"); tick();
        count_i = 200; cap_stb_i = 4'b0010; expect_v(1, 200, "R1 slot2"); tick();
        count_i = 300; cap_stb_i = 4'b1100;
        expect_v(2, 300, "R1 slot3"); expect_v(3, 300, "R1 slot4"); tick();
        // R6: plain write, then strobe beats write on the same edge
        bus_wr(0, 55); expect_v(0, 55, "R6 write"); tick();
        bus_wr(0, 66); count_i = 400; cap_stb_i = 4'b0001;
        expect_v(0, 400, "R6 strobe wins"); tick();
        // R7: shadow write with count equal to reg1 does not reach reg1
        bus_wr(2, 77); count_i = 400;
        expect_v(2, 77, "R7 shadow write"); expect_v(0, 400, "R7 lockout"); tick();
        // R2: load-enable clear blocks all strobes
        lden_wr_i = 1'b1; lden_wdata_i = 1'b0; expect_v(4, 0, "R5 clear"); tick();
        count_i = 500; cap_stb_i = 4'b1111;
        expect_all(400, 200, 77, 300, 1'b0, "R2 inhibit"); tick();
        // R3: one-shot stop at index 1
        lden_wr_i = 1'b1; lden_wdata_i = 1'b1; oneshot_i = 1'b1; stop_idx_i = 2'd1;
        expect_v(4, 1, "R5 rearm"); tick();
        count_i = 600; cap_stb_i = 4'b0001;
        expect_v(0, 600, "R3 pre-stop"); expect_v(4, 1, "R3 still armed"); tick();
        count_i = 700; cap_stb_i = 4'b0010;
        expect_v(1, 700, "R3 stop capture"); expect_v(4, 0, "R3 auto clear"); tick();
        count_i = 800; cap_stb_i = 4'b0100;
        expect_v(2, 77, "R3 after stop"); tick();
        // R5: re-arm, then re-arm write beats stop on the same edge
        lden_wr_i = 1'b1; lden_wdata_i = 1'b1; stop_idx_i = 2'd0;
        expect_v(4, 1, "R5 rearm2"); tick();
        lden_wr_i = 1'b1; lden_wdata_i = 1'b1; count_i = 900; cap_stb_i = 4'b0001;
        expect_v(0, 900, "R5 capture"); expect_v(4, 1, "R5 write beats stop"); tick();
        // R4: continuous mode keeps load-enable
        oneshot_i = 1'b0; count_i = 950; cap_stb_i = 4'b0001;
        expect_v(0, 950, "R4 capture"); expect_v(4, 1, "R4 hold"); tick();
        // R8: PWM mode ignores strobes
        pwm_mode_i = 1'b1; shadow_imm_i = 1'b1; count_i = 1000; cap_stb_i = 4'b1111;
        expect_all(950, 700, 77, 300, 1'b1, "R8 ignore"); tick();
        // R9: immediate shadow loads
        bus_wr(2, 40); expect_v(2, 40, "R9 shadow per"); expect_v(0, 40, "R9 active per"); tick();
        bus_wr(3, 10); expect_v(3, 10, "R9 shadow cmp"); expect_v(1, 10, "R9 active cmp"); tick();
        // R10: deferred shadow loads
        shadow_imm_i = 1'b0; count_i = 5;
        bus_wr(2, 60); expect_v(2, 60, "R10 shadow"); expect_v(0, 40, "R10 no match"); tick();
        bus_wr(3, 15); expect_v(3, 15, "R10 shadow cmp"); expect_v(1, 10, "R10 no match cmp"); tick();
        count_i = 40; bus_wr(2, 80);
        expect_all(60, 15, 80, 15, 1'b1, "R10 match with write"); tick();
        count_i = 41;
        expect_all(60, 15, 80, 15, 1'b1, "R10 between matches"); tick();
        count_i = 60;
        expect_all(80, 15, 80, 15, 1'b1, "R10 next match"); tick();
        // R11: reset again
        pwm_mode_i = 1'b0; rst_n = 1'b0;
        expect_all(0, 0, 0, 0, 1'b0, "R11 re-reset"); tick();
        rst_n = 1'b1;
        tick();
        tick();
        done = 1'b1;
        if (exp_q.size() != 0) begin
            n_checks++;
            n_fail++;
            $display("FAIL scoreboard: got %0d pending expected 0", exp_q.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule